// File: doc/BRIEF.md
# CAN Controller Interrupt Flag Register

This block gathers the interrupt sources of a CAN controller into one 8-bit flag register and drives a single interrupt request line to the CPU. Each source has its own trigger rule. Some flags set on a rising edge of a status bit and one sets on any change of either of two status bits. The error-passive flag watches a state transition and two error counters crossing a limit. Other flags take single-cycle event pulses from the protocol engine. The receive flag is a plain level that mirrors the receive-buffer status. A flag can set only while its enable bit is high.

The CPU reads the register over a 32-bit read bus. A read is a strobe qualified by an address-select line, and it is always accepted in the cycle it is presented. There is no back-pressure and no wait state. The read data is combinational while the select line is high. At the clock edge that ends a selected read, every flag except the receive flag is cleared. If a source fires in that same cycle, its flag stays set, so no event is lost. The protocol engine, the error counters, the receive FIFO and the other controller registers are outside this block.

Top module: `can_irq_flag_reg`

## Requirements
- R1: When `rd_sel` is high, `rd_data[7:0]` shows the flags in this order: bit 7 bus error, bit 6 arbitration lost, bit 5 error passive, bit 4 wake-up, bit 3 data overrun, bit 2 error warning, bit 1 transmit, bit 0 receive.
- R2: `rd_data` bits 31 to 8 always read zero. All of `rd_data` reads zero while `rd_sel` is low.
- R3: `irq` is high exactly when at least one flag is set.
- R4: Flag n can go from 0 to 1 only in a cycle where `irq_en[n]` is high. A set flag stays set if its enable later drops.
- R5: A read is a cycle with both `rd_en` and `rd_sel` high. A read clears flags 7 to 1 at that clock edge. Without a read, those flags hold their value.
- R6: Flag 0 equals `irq_en[0] & st_rx_full` as sampled at the previous clock edge. Reads do not affect it.
- R7: Flag 3 sets when `st_overrun` is high at an edge after being low at the previous edge.
- R8: Flag 2 sets when `st_err_warn` or `st_bus_off` differs from its value at the previous edge, in either direction.
- R9: Flag 1 sets when `st_tx_free` goes from low to high between consecutive edges.
- R10: Flag 5 sets on either of two conditions. The first is `st_err_passive` falling from high to low. The second is `tx_err_cnt` or `rx_err_cnt` becoming greater than ERR_LIMIT (default 127) when it was not greater at the previous edge.
- R11: Flag 4 sets on either of two conditions. The first is an `ev_bus_wake` pulse. The second is an `ev_sleep_req` pulse while `bus_active` is high or any flag is already set.
- R12: Flag 7 sets on an `ev_bus_err` pulse and flag 6 sets on an `ev_arb_lost` pulse.
- R13: When a set condition and a read fall in the same cycle, the flag is set after that edge.
- R14: Reset clears all flags. The history of the status bits and counters is reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_en | input | 8 | Per-flag enable bits |
| st_rx_full | input | 1 | Receive buffer holds at least one message |
| st_overrun | input | 1 | Data overrun status |
| st_tx_free | input | 1 | Transmit buffer released status |
| st_err_warn | input | 1 | Error-warning status |
| st_bus_off | input | 1 | Bus-off status |
| st_err_passive | input | 1 | Controller is in the error-passive state |
| tx_err_cnt | input | CNT_W | Transmit error counter |
| rx_err_cnt | input | CNT_W | Receive error counter |
| ev_bus_err | input | 1 | Pulse: error detected on the bus |
| ev_arb_lost | input | 1 | Pulse: arbitration lost |
| ev_bus_wake | input | 1 | Pulse: bus activity detected |
| ev_sleep_req | input | 1 | Pulse: CPU attempts to enter sleep mode |
| bus_active | input | 1 | Controller is involved in bus traffic |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 1 | Address match for this register |
| rd_data | output | DATA_W | Read data |
| irq | output | 1 | Interrupt request to the CPU |

## Verification
The bench builds the block with its defaults: a 32-bit read bus, 8-bit error counters and a limit of 127. The counters are swept at random across a narrow window around 127, so crossings upward, drops back down and repeat crossings occur many times. With 8-bit counters and this window, both counters can cross in the same cycle, and a counter can cross in a cycle where the passive-to-active transition also happens.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int FLAG_W   = 8;
  localparam int BIT_RX   = 0;
  localparam int BIT_TX   = 1;
  localparam int BIT_WARN = 2;
  localparam int BIT_OVR  = 3;
  localparam int BIT_WAKE = 4;
  localparam int BIT_PASV = 5;
  localparam int BIT_ARB  = 6;
  localparam int BIT_BERR = 7;
  localparam int NUM_CNT  = 2;

  typedef logic [FLAG_W-1:0] flag_vec_t;

  typedef struct packed {
    logic overrun;
    logic tx_free;
    logic err_warn;
    logic bus_off;
    logic err_passive;
  } status_hist_t;
endpackage

// File: rtl/can_irq_cross.sv
module can_irq_cross #(
  parameter int CNT_W = 8,
  parameter int LIMIT = 127
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  output logic             crossed
);
  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LIMIT);

  logic above;
  logic above_q;

  assign above = (cnt > LIMIT_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) above_q <= 1'b0;
    else        above_q <= above;
  end

  assign crossed = above & ~above_q;
endmodule

// File: rtl/can_irq_trigger.sv
module can_irq_trigger
  import can_irq_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int LIMIT = 127
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             st_overrun,
  input  logic             st_tx_free,
  input  logic             st_err_warn,
  input  logic             st_bus_off,
  input  logic             st_err_passive,
  input  logic [CNT_W-1:0] tx_err_cnt,
  input  logic [CNT_W-1:0] rx_err_cnt,
  input  logic             ev_bus_err,
  input  logic             ev_arb_lost,
  input  logic             ev_bus_wake,
  input  logic             ev_sleep_req,
  input  logic             bus_active,
  input  logic             irq_pending,
  output flag_vec_t        set_req
);
  status_hist_t cur;
  status_hist_t prev;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnts;
  logic [NUM_CNT-1:0]            cnt_cross;

  assign cur.overrun     = st_overrun;
  assign cur.tx_free     = st_tx_free;
  assign cur.err_warn    = st_err_warn;
  assign cur.bus_off     = st_bus_off;
  assign cur.err_passive = st_err_passive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= cur;
  end

  assign cnts[0] = tx_err_cnt;
  assign cnts[1] = rx_err_cnt;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cross
    can_irq_cross #(.CNT_W(CNT_W), .LIMIT(LIMIT)) u_cross (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt     (cnts[g]),
      .crossed (cnt_cross[g])
    );
  end

  always_comb begin
    set_req           = '0;
    set_req[BIT_BERR] = ev_bus_err;
    set_req[BIT_ARB]  = ev_arb_lost;
    set_req[BIT_PASV] = (prev.err_passive & ~cur.err_passive) | (|cnt_cross);
    set_req[BIT_WAKE] = ev_bus_wake | (ev_sleep_req & (bus_active | irq_pending));
    set_req[BIT_OVR]  = cur.overrun & ~prev.overrun;
    set_req[BIT_WARN] = (cur.err_warn ^ prev.err_warn) | (cur.bus_off ^ prev.bus_off);
    set_req[BIT_TX]   = cur.tx_free & ~prev.tx_free;
    set_req[BIT_RX]   = 1'b0;
  end

  assert_wake_sleep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sleep_req && bus_active) |-> set_req[BIT_WAKE]);
  assert_pasv_cross_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_err_cnt > CNT_W'(LIMIT) && !$stable(tx_err_cnt) && $past(tx_err_cnt) <= CNT_W'(LIMIT))
      |-> set_req[BIT_PASV]);
endmodule

// File: rtl/can_irq_flags.sv
module can_irq_flags
  import can_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  flag_vec_t set_req,
  input  flag_vec_t irq_en,
  input  logic      rx_full,
  input  logic      rd_clr,
  output flag_vec_t flags
);
  flag_vec_t set_gated;
  logic      armed;

  assign set_gated = set_req & irq_en;

  for (genvar i = 1; i < FLAG_W; i++) begin : g_sticky
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            flags[i] <= 1'b0;
      else if (set_gated[i]) flags[i] <= 1'b1;
      else if (rd_clr)       flags[i] <= 1'b0;
    end

    assert_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags[i] && !irq_en[i]) |=> !flags[i]);
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && !rd_clr) |=> flags[i]);
    assert_set_wins_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && set_req[i] && irq_en[i]) |=> flags[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags[BIT_RX] <= 1'b0;
    else        flags[BIT_RX] <= irq_en[BIT_RX] & rx_full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_rx_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (flags[BIT_RX] == $past(irq_en[BIT_RX] && rx_full)));
  assert_read_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && ((set_req[FLAG_W-1:1] & irq_en[FLAG_W-1:1]) == '0)) |=> (flags[FLAG_W-1:1] == '0));
endmodule

// File: rtl/can_irq_flag_reg.sv
module can_irq_flag_reg
  import can_irq_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 8,
  parameter int ERR_LIMIT = 127
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        irq_en,
  input  logic              st_rx_full,
  input  logic              st_overrun,
  input  logic              st_tx_free,
  input  logic              st_err_warn,
  input  logic              st_bus_off,
  input  logic              st_err_passive,
  input  logic [CNT_W-1:0]  tx_err_cnt,
  input  logic [CNT_W-1:0]  rx_err_cnt,
  input  logic              ev_bus_err,
  input  logic              ev_arb_lost,
  input  logic              ev_bus_wake,
  input  logic              ev_sleep_req,
  input  logic              bus_active,
  input  logic              rd_en,
  input  logic              rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  localparam int PAD_W = DATA_W - FLAG_W;

  flag_vec_t set_req;
  flag_vec_t flags;
  logic      rd_clr;

  assign rd_clr = rd_en & rd_sel;
  assign irq    = |flags;

  can_irq_trigger #(.CNT_W(CNT_W), .LIMIT(ERR_LIMIT)) u_trigger (
    .clk            (clk),
    .rst_n          (rst_n),
    .st_overrun     (st_overrun),
    .st_tx_free     (st_tx_free),
    .st_err_warn    (st_err_warn),
    .st_bus_off     (st_bus_off),
    .st_err_passive (st_err_passive),
    .tx_err_cnt     (tx_err_cnt),
    .rx_err_cnt     (rx_err_cnt),
    .ev_bus_err     (ev_bus_err),
    .ev_arb_lost    (ev_arb_lost),
    .ev_bus_wake    (ev_bus_wake),
    .ev_sleep_req   (ev_sleep_req),
    .bus_active     (bus_active),
    .irq_pending    (irq),
    .set_req        (set_req)
  );

  can_irq_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_req (set_req),
    .irq_en  (irq_en),
    .rx_full (st_rx_full),
    .rd_clr  (rd_clr),
    .flags   (flags)
  );

  assign rd_data = rd_sel ? {{PAD_W{1'b0}}, flags} : '0;

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DATA_W-1:FLAG_W] == '0);
  assert_irq_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel && rd_data[FLAG_W-1:0] != '0) |-> irq);
endmodule

// File: tb/can_irq_flag_reg_tb.sv
module can_irq_flag_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq_en = '0;
  logic        st_rx_full = 0, st_overrun = 0, st_tx_free = 0;
  logic        st_err_warn = 0, st_bus_off = 0, st_err_passive = 0;
  logic [7:0]  tx_err_cnt = '0, rx_err_cnt = '0;
  logic        ev_bus_err = 0, ev_arb_lost = 0, ev_bus_wake = 0, ev_sleep_req = 0;
  logic        bus_active = 0, rd_en = 0, rd_sel = 0;
  logic [31:0] rd_data;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 0;

  logic [7:0] m_flags = '0;
  logic p_ovr = 0, p_tx = 0, p_warn = 0, p_boff = 0, p_pasv = 0;
  logic p_tx_above = 0, p_rx_above = 0;

  always #10 clk = ~clk;

  can_irq_flag_reg u_dut (
    .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .st_rx_full(st_rx_full),
    .st_overrun(st_overrun), .st_tx_free(st_tx_free), .st_err_warn(st_err_warn),
    .st_bus_off(st_bus_off), .st_err_passive(st_err_passive),
    .tx_err_cnt(tx_err_cnt), .rx_err_cnt(rx_err_cnt), .ev_bus_err(ev_bus_err),
    .ev_arb_lost(ev_arb_lost), .ev_bus_wake(ev_bus_wake), .ev_sleep_req(ev_sleep_req),
    .bus_active(bus_active), .rd_en(rd_en), .rd_sel(rd_sel),
    .rd_data(rd_data), .irq(irq)
  );

  function automatic string req_of(int b);
    case (b)
      7, 6: return "R12";
      5: return "R10";
      4: return "R11";
      3: return "R7";
      2: return "R8";
      1: return "R9";
      default: return "R6";
    endcase
  endfunction

  function automatic logic [7:0] next_flags();
    logic [7:0] s;
    logic [7:0] n;
    s = '0;
    s[7] = ev_bus_err;
    s[6] = ev_arb_lost;
    s[5] = (p_pasv & ~st_err_passive) | ((tx_err_cnt > 8'd127) & ~p_tx_above)
         | ((rx_err_cnt > 8'd127) & ~p_rx_above);
    s[4] = ev_bus_wake | (ev_sleep_req & (bus_active | (m_flags != 0)));
    s[3] = st_overrun & ~p_ovr;
    s[2] = (st_err_warn ^ p_warn) | (st_bus_off ^ p_boff);
    s[1] = st_tx_free & ~p_tx;
    s = s & irq_en;
    n[7:1] = s[7:1] | (m_flags[7:1] & ~{7{rd_en & rd_sel}});
    n[0] = irq_en[0] & st_rx_full;
    return n;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    m_flags = next_flags();
    p_ovr = st_overrun; p_tx = st_tx_free; p_warn = st_err_warn;
    p_boff = st_bus_off; p_pasv = st_err_passive;
    p_tx_above = tx_err_cnt > 8'd127; p_rx_above = rx_err_cnt > 8'd127;
    @(negedge clk);
    cycles++;
    check("R3", {31'd0, irq}, {31'd0, m_flags != 0});
    if (rd_sel) begin
      check("R2", {24'd0, rd_data[31:8]}, 32'd0);
      for (int b = 0; b < 8; b++)
        check(req_of(b), {31'd0, rd_data[b]}, {31'd0, m_flags[b]});
    end else begin
      check("R2", rd_data, 32'd0);
    end
  endtask

  task automatic quiet();
    ev_bus_err = 0; ev_arb_lost = 0; ev_bus_wake = 0; ev_sleep_req = 0;
    rd_en = 0; rd_sel = 1;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      if (cycles > 150000) begin
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks + 1);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    st_rx_full = 1;
    irq_en = 8'hFF;
    rd_sel = 1;
    repeat (3) @(negedge clk);
    // R14: flags clear during reset
    check("R14", rd_data, 32'd0);
    check("R14", {31'd0, irq}, 32'd0);
    st_rx_full = 0;
    rst_n = 1;
    quiet();
    step();

    // R1: only bus error fires -> bit 7 alone
    ev_bus_err = 1; step(); quiet();
    check("R1", rd_data, 32'h0000_0080);
    // R5: read clears bits 7..1
    rd_en = 1; step(); quiet();
    check("R5", rd_data, 32'd0);
    // R4: disabled source does not set
    irq_en = 8'h7F; ev_bus_err = 1; step(); quiet();
    check("R4", rd_data, 32'd0);
    irq_en = 8'hFF;
    // R13: set and read same cycle -> set wins
    ev_arb_lost = 1; step(); quiet();
    st_overrun = 1; rd_en = 1; step(); quiet();
    check("R13", rd_data, 32'h0000_0008);
    // R6: rx flag follows status and survives reads
    st_rx_full = 1; step(); rd_en = 1; step(); quiet();
    check("R6", {31'd0, rd_data[0]}, 32'd1);
    st_rx_full = 0; step();
    check("R6", {31'd0, rd_data[0]}, 32'd0);
    // R8: falling edge of warn also sets
    st_err_warn = 1; step(); rd_en = 1; step(); quiet();
    st_err_warn = 0; step();
    check("R8", {31'd0, rd_data[2]}, 32'd1);
    // R10: passive-to-active transition and counter crossing
    rd_en = 1; step(); quiet();
    st_err_passive = 1; step(); check("R10", {31'd0, rd_data[5]}, 32'd0);
    st_err_passive = 0; step(); check("R10", {31'd0, rd_data[5]}, 32'd1);
    rd_en = 1; step(); quiet();
    rx_err_cnt = 8'd127; step(); check("R10", {31'd0, rd_data[5]}, 32'd0);
    rx_err_cnt = 8'd128; step(); check("R10", {31'd0, rd_data[5]}, 32'd1);
    // R11: sleep attempt with bus idle and no flags pending -> no wake
    rd_en = 1; step(); quiet(); step();
    ev_sleep_req = 1; step(); quiet();
    check("R11", {31'd0, rd_data[4]}, 32'd0);
    bus_active = 1; ev_sleep_req = 1; step(); quiet();
    check("R11", {31'd0, rd_data[4]}, 32'd1);
    bus_active = 0;

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      irq_en       = ($urandom_range(0, 9) == 0) ? 8'($urandom) : 8'hFF;
      st_rx_full   = ($urandom_range(0, 3) == 0) ? ~st_rx_full : st_rx_full;
      st_overrun   = ($urandom_range(0, 4) == 0) ? ~st_overrun : st_overrun;
      st_tx_free   = ($urandom_range(0, 4) == 0) ? ~st_tx_free : st_tx_free;
      st_err_warn  = ($urandom_range(0, 6) == 0) ? ~st_err_warn : st_err_warn;
      st_bus_off   = ($urandom_range(0, 8) == 0) ? ~st_bus_off : st_bus_off;
      st_err_passive = ($urandom_range(0, 5) == 0) ? ~st_err_passive : st_err_passive;
      tx_err_cnt   = 8'($urandom_range(122, 132));
      rx_err_cnt   = 8'($urandom_range(124, 130));
      ev_bus_err   = ($urandom_range(0, 15) == 0);
      ev_arb_lost  = ($urandom_range(0, 15) == 0);
      ev_bus_wake  = ($urandom_range(0, 20) == 0);
      ev_sleep_req = ($urandom_range(0, 10) == 0);
      bus_active   = ($urandom_range(0, 2) == 0);
      rd_sel       = ($urandom_range(0, 7) != 0);
      rd_en        = ($urandom_range(0, 3) == 0);
      step();
    end
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule